// File: doc/BRIEF.md
# Programmable Interval Timer

A down-counting interval timer attached to a simple word-addressed register port. Software writes a 32-bit reload value as two 16-bit halves. It then sets the mode bits and issues a start strobe. The counter loads the reload value and decrements once per clock. When it reaches zero, the next cycle raises a sticky timeout flag. In continuous mode the counter then reloads and keeps running. In one-shot mode it halts at zero.

An explicit stop strobe freezes the count. Any write to a capture register copies the live count into a holding register, and software can read that copy half by half without racing the counter. One interrupt request line follows the timeout flag, gated by an interrupt-enable bit. Reads are registered, so read data appears on the clock edge that follows the read request.

Top module: `ivl_timer`

## Requirements
- R1: The byte address selects a register: 0x00 status, 0x04 control, 0x08 reload low, 0x0C reload high, 0x10 capture low, 0x14 capture high. Any other address, including one with addr[1:0] nonzero, reads as zero and ignores writes. A read with rd_en updates rdata at the next rising edge, and rdata holds its value otherwise.
- R2: After reset, status and control read 0, irq is 0, the capture registers read 0, and the reload value equals the parameter RESET_LOAD (default 100000, so low half 0x86A0 and high half 0x0001).
- R3: The reload and capture registers keep only wdata[15:0]. Bits 31..16 of those registers read as zero.
- R4: In the control register, bit 0 is the interrupt enable, bit 1 is continuous mode, bit 2 is the start strobe and bit 3 is the stop strobe. Writing bit 2 as 1 loads the counter from the 32-bit reload value and sets the running bit. Only bits 1..0 are stored; bits 3..2 and all bits above read back as zero.
- R5: Status bit 0 is the timeout flag and status bit 1 is the running bit; every other status bit reads zero. With reload value L, the timeout flag rises at the (L+1)-th rising edge after the start edge.
- R6: With continuous mode set, a timeout reloads the counter from the reload value and leaves the running bit set.
- R7: With continuous mode clear, a timeout clears the running bit and the count stays at zero.
- R8: A stop strobe clears the running bit and freezes the count. When start and stop are written together, stop wins and the timer does not run.
- R9: Any write to the status register clears the timeout flag. A timeout in the same cycle takes priority and leaves the flag set.
- R10: Any write to either capture address copies the count as it stood before that edge into the 32-bit holding register. The low and high capture addresses then read its two halves.
- R11: irq is 1 exactly when the timeout flag and the interrupt enable are both 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write request for the register at addr |
| rd_en | input | 1 | Read request for the register at addr |
| addr | input | 5 | Byte address of the register |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Registered read data |
| irq | output | 1 | Interrupt request |

## Verification
A counter that is off by one shows up as a timeout flag, and therefore an irq edge, one cycle early or late. The reference model tracks every clock, so the very next status read or irq sample disagrees with it. A stuck or mis-prioritised running bit appears on the next status read. A wrong reload or freeze appears as a capture value that differs from the model's count within a few cycles. A strobe that is stored by mistake appears on the next control read.

// File: rtl/ivl_timer_pkg.sv
package ivl_timer_pkg;
  localparam int unsigned ADDR_W = 5;
  localparam int unsigned DATA_W = 32;

  localparam logic [2:0] WD_STATUS  = 3'd0;
  localparam logic [2:0] WD_CTRL    = 3'd1;
  localparam logic [2:0] WD_LOAD_LO = 3'd2;
  localparam logic [2:0] WD_LOAD_HI = 3'd3;
  localparam logic [2:0] WD_SNAP_LO = 3'd4;
  localparam logic [2:0] WD_SNAP_HI = 3'd5;

  localparam int unsigned CB_IEN   = 0;
  localparam int unsigned CB_CONT  = 1;
  localparam int unsigned CB_START = 2;
  localparam int unsigned CB_STOP  = 3;

  typedef struct packed {
    logic start;
    logic stop;
    logic clr_to;
  } tmr_cmd_t;
endpackage

// File: rtl/ivl_timer_core.sv
module ivl_timer_core #(
  parameter int unsigned CNT_W = 32
) (
  input  logic                 clk,
  input  logic                 rst,
  input  ivl_timer_pkg::tmr_cmd_t cmd_i,
  input  logic                 cont_i,
  input  logic [CNT_W-1:0]     load_i,
  output logic [CNT_W-1:0]     cnt_o,
  output logic                 run_o,
  output logic                 to_o
);
  logic [CNT_W-1:0] cnt_q;
  logic             run_q;
  logic             to_q;
  logic             expire;
  logic             at_zero;

  assign at_zero = (cnt_q == '0);
  assign expire  = run_q & ~cmd_i.start & ~cmd_i.stop & at_zero;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
      run_q <= 1'b0;
    end else if (cmd_i.stop) begin
      run_q <= 1'b0;
    end else if (cmd_i.start) begin
      cnt_q <= load_i;
      run_q <= 1'b1;
    end else if (run_q) begin
      if (at_zero) begin
        if (cont_i) cnt_q <= load_i;
        else        run_q <= 1'b0;
      end else begin
        cnt_q <= cnt_q - 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst)               to_q <= 1'b0;
    else if (expire)       to_q <= 1'b1;
    else if (cmd_i.clr_to) to_q <= 1'b0;
  end

  assign cnt_o = cnt_q;
  assign run_o = run_q;
  assign to_o  = to_q;

  AST_STOP_HALTS: assert property (@(posedge clk) disable iff (rst)
    cmd_i.stop |=> !run_q); // R8
  AST_START_RUNS: assert property (@(posedge clk) disable iff (rst)
    (cmd_i.start && !cmd_i.stop) |=> (run_q && cnt_q == $past(load_i))); // R4
  AST_IDLE_FROZEN: assert property (@(posedge clk) disable iff (rst)
    (!run_q && !cmd_i.start) |=> $stable(cnt_q)); // R8
  AST_ONESHOT_END: assert property (@(posedge clk) disable iff (rst)
    (run_q && at_zero && !cont_i && !cmd_i.start && !cmd_i.stop) |=> (!run_q && to_q)); // R7
  AST_CONT_KEEPS: assert property (@(posedge clk) disable iff (rst)
    (run_q && at_zero && cont_i && !cmd_i.start && !cmd_i.stop) |=> (run_q && to_q)); // R6
  AST_TO_STICKY: assert property (@(posedge clk) disable iff (rst)
    (to_q && !cmd_i.clr_to) |=> to_q); // R9
endmodule

// File: rtl/ivl_timer_regs.sv
module ivl_timer_regs #(
  parameter int unsigned HALF_W     = 16,
  parameter logic [2*HALF_W-1:0] RESET_LOAD = 100000
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          wr_en,
  input  logic                          rd_en,
  input  logic [ivl_timer_pkg::ADDR_W-1:0] addr,
  input  logic [ivl_timer_pkg::DATA_W-1:0] wdata,
  input  logic [2*HALF_W-1:0]           cnt_i,
  input  logic                          run_i,
  input  logic                          to_i,
  output logic [ivl_timer_pkg::DATA_W-1:0] rdata,
  output logic                          ien_o,
  output logic                          cont_o,
  output logic [2*HALF_W-1:0]           load_o,
  output ivl_timer_pkg::tmr_cmd_t       cmd_o
);
  import ivl_timer_pkg::*;
  localparam int unsigned CNT_W = 2 * HALF_W;
  localparam int unsigned PAD_W = DATA_W - HALF_W;

  logic [2:0]       word;
  logic             aligned;
  logic             wr_ok;
  logic [HALF_W-1:0] load_half [2];
  logic [CNT_W-1:0] snap_q;
  logic             ien_q, cont_q;
  logic [DATA_W-1:0] rd_mux;
  logic             unused_bits;

  assign word    = addr[ADDR_W-1:2];
  assign aligned = (addr[1:0] == 2'b00);
  assign wr_ok   = wr_en & aligned;

  genvar h;
  generate
    for (h = 0; h < 2; h++) begin : g_load
      always_ff @(posedge clk) begin
        if (rst)
          load_half[h] <= RESET_LOAD[h*HALF_W +: HALF_W];
        else if (wr_ok && word == (WD_LOAD_LO + 3'(h)))
          load_half[h] <= wdata[HALF_W-1:0];
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      ien_q  <= 1'b0;
      cont_q <= 1'b0;
    end else if (wr_ok && word == WD_CTRL) begin
      ien_q  <= wdata[CB_IEN];
      cont_q <= wdata[CB_CONT];
    end
  end

  always_ff @(posedge clk) begin
    if (rst)
      snap_q <= '0;
    else if (wr_ok && (word == WD_SNAP_LO || word == WD_SNAP_HI))
      snap_q <= cnt_i;
  end

  always_comb begin
    rd_mux = '0;
    if (aligned) begin
      case (word)
        WD_STATUS:  rd_mux = {{(DATA_W-2){1'b0}}, run_i, to_i};
        WD_CTRL:    rd_mux = {{(DATA_W-2){1'b0}}, cont_q, ien_q};
        WD_LOAD_LO: rd_mux = {{PAD_W{1'b0}}, load_half[0]};
        WD_LOAD_HI: rd_mux = {{PAD_W{1'b0}}, load_half[1]};
        WD_SNAP_LO: rd_mux = {{PAD_W{1'b0}}, snap_q[HALF_W-1:0]};
        WD_SNAP_HI: rd_mux = {{PAD_W{1'b0}}, snap_q[CNT_W-1:HALF_W]};
        default:    rd_mux = '0;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst)        rdata <= '0;
    else if (rd_en) rdata <= rd_mux;
  end

  assign cmd_o.start  = wr_ok && word == WD_CTRL && wdata[CB_START];
  assign cmd_o.stop   = wr_ok && word == WD_CTRL && wdata[CB_STOP];
  assign cmd_o.clr_to = wr_ok && word == WD_STATUS;
  assign load_o = {load_half[1], load_half[0]};
  assign ien_o  = ien_q;
  assign cont_o = cont_q;
  assign unused_bits = ^wdata[DATA_W-1:HALF_W];

  AST_HALF_UPPER_ZERO: assert property (@(posedge clk) disable iff (rst)
    (rd_en && aligned && word >= WD_LOAD_LO && word <= WD_SNAP_HI)
      |=> (rdata[DATA_W-1:HALF_W] == '0)); // R3
  AST_STATUS_PAD_ZERO: assert property (@(posedge clk) disable iff (rst)
    (rd_en && aligned && word <= WD_CTRL) |=> (rdata[DATA_W-1:2] == '0)); // R5
  AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (rst)
    !rd_en |=> $stable(rdata)); // R1
  AST_SNAP_COPIES: assert property (@(posedge clk) disable iff (rst)
    (wr_ok && word == WD_SNAP_HI) |=> (snap_q == $past(cnt_i))); // R10
endmodule

// File: rtl/ivl_timer.sv
module ivl_timer #(
  parameter int unsigned HALF_W     = 16,
  parameter logic [2*HALF_W-1:0] RESET_LOAD = 100000
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        wr_en,
  input  logic        rd_en,
  input  logic [4:0]  addr,
  input  logic [31:0] wdata,
  output logic [31:0] rdata,
  output logic        irq
);
  localparam int unsigned CNT_W = 2 * HALF_W;

  ivl_timer_pkg::tmr_cmd_t cmd;
  logic             ien, cont, run, to;
  logic [CNT_W-1:0] load, cnt;

  ivl_timer_regs #(.HALF_W(HALF_W), .RESET_LOAD(RESET_LOAD)) u_regs (
    .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .cnt_i(cnt), .run_i(run), .to_i(to), .rdata(rdata),
    .ien_o(ien), .cont_o(cont), .load_o(load), .cmd_o(cmd)
  );

  ivl_timer_core #(.CNT_W(CNT_W)) u_core (
    .clk(clk), .rst(rst), .cmd_i(cmd), .cont_i(cont), .load_i(load),
    .cnt_o(cnt), .run_o(run), .to_o(to)
  );

  assign irq = to & ien;

  AST_IRQ_NEEDS_FLAG: assert property (@(posedge clk) disable iff (rst)
    (cmd.clr_to && !(run && cnt == '0)) |=> !irq); // R11
endmodule

// File: tb/ivl_timer_tb.sv
`timescale 1ns/1ps
module ivl_timer_tb;
  localparam logic [31:0] RST_LOAD = 32'd100000;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0, rd_en = 1'b0;
  logic [4:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        irq;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  ivl_timer u_dut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .irq(irq)
  );

  // behavioural reference model
  logic [15:0] m_lo, m_hi;
  logic        m_ien, m_cont, m_run, m_to;
  logic [31:0] m_cnt, m_snap, m_rd;

  always @(posedge clk) begin
    if (rst) begin
      m_lo = RST_LOAD[15:0]; m_hi = RST_LOAD[31:16];
      m_ien = 0; m_cont = 0; m_run = 0; m_to = 0;
      m_cnt = 0; m_snap = 0; m_rd = 0;
    end else begin
      int w;
      bit ok, wr, go, halt, fire;
      logic [31:0] rv, ld;
      w  = int'(addr) / 4;
      ok = (addr % 4) == 0;
      rv = 0;
      if (ok) begin
        if (w == 0) rv = {30'd0, m_run, m_to};
        else if (w == 1) rv = {30'd0, m_cont, m_ien};
        else if (w == 2) rv = {16'd0, m_lo};
        else if (w == 3) rv = {16'd0, m_hi};
        else if (w == 4) rv = {16'd0, m_snap[15:0]};
        else if (w == 5) rv = {16'd0, m_snap[31:16]};
      end
      if (rd_en) m_rd = rv;
      wr   = wr_en && ok;
      go   = wr && w == 1 && wdata[2];
      halt = wr && w == 1 && wdata[3];
      fire = m_run && !go && !halt && m_cnt == 0;
      ld   = {m_hi, m_lo};
      if (wr && (w == 4 || w == 5)) m_snap = m_cnt;
      if (fire) m_to = 1;
      else if (wr && w == 0) m_to = 0;
      if (halt) m_run = 0;
      else if (go) begin m_cnt = ld; m_run = 1; end
      else if (m_run) begin
        if (m_cnt == 0) begin
          if (m_cont) m_cnt = ld; else m_run = 0;
        end else m_cnt = m_cnt - 1;
      end
      if (wr && w == 1) begin m_ien = wdata[0]; m_cont = wdata[1]; end
      if (wr && w == 2) m_lo = wdata[15:0];
      if (wr && w == 3) m_hi = wdata[15:0];
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=0x%08h expected=0x%08h", tag, act, exp);
    end
  endtask

  // per-cycle comparison against the model
  always @(negedge clk) begin
    if (!rst && !finished) begin
      chk("R1 rdata vs model", rdata, m_rd);
      chk("R11 irq vs model", {31'd0, irq}, {31'd0, m_to & m_ien});
    end
  end

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [31:0] d);
    addr = a; rd_en = 1'b1;
    @(negedge clk);
    rd_en = 1'b0;
    d = rdata;
  endtask

  task automatic finish_run();
    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    logic [31:0] v, v1, v2;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R2 reset values
    chk("R2 irq after reset", {31'd0, irq}, 32'd0);
    rd(5'h00, v); chk("R2 status", v, 32'h0);
    rd(5'h04, v); chk("R2 control", v, 32'h0);
    rd(5'h08, v); chk("R2 reload low", v, 32'h86A0);
    rd(5'h0C, v); chk("R2 reload high", v, 32'h0001);
    rd(5'h10, v); chk("R2 capture low", v, 32'h0);
    // R3 halves keep 16 bits
    wr(5'h08, 32'hABCD_0005); rd(5'h08, v); chk("R3 reload low", v, 32'h0005);
    wr(5'h0C, 32'hFFFF_0000); rd(5'h0C, v); chk("R3 reload high", v, 32'h0000);
    // R7 one-shot with interrupt enabled, L=5
    wr(5'h04, 32'h5);
    repeat (12) @(negedge clk);
    rd(5'h00, v); chk("R7 status after one-shot", v, 32'h1);
    chk("R11 irq with enable", {31'd0, irq}, 32'd1);
    rd(5'h04, v); chk("R4 strobe not stored", v, 32'h1);
    wr(5'h10, 32'h0); rd(5'h10, v); chk("R7 count held at zero", v, 32'h0);
    // R9 clear
    wr(5'h00, 32'h0); rd(5'h00, v); chk("R9 status cleared", v, 32'h0);
    chk("R11 irq after clear", {31'd0, irq}, 32'd0);
    // R6 continuous, interrupts disabled
    wr(5'h04, 32'h6);
    rd(5'h00, v); chk("R5 running before timeout", v, 32'h2);
    repeat (20) @(negedge clk);
    rd(5'h00, v); chk("R6 running with flag", v, 32'h3);
    chk("R11 irq masked", {31'd0, irq}, 32'd0);
    // R8 stop freezes
    wr(5'h04, 32'h8);
    wr(5'h10, 32'h0); rd(5'h10, v1);
    repeat (5) @(negedge clk);
    wr(5'h14, 32'h0); rd(5'h10, v2);
    chk("R8 frozen count", v2, v1);
    rd(5'h00, v); chk("R8 stopped", v, 32'h1);
    wr(5'h00, 32'h0);
    wr(5'h04, 32'hC); rd(5'h00, v); chk("R8 stop beats start", v, 32'h0);
    wr(5'h04, 32'hF3); rd(5'h04, v); chk("R4 only mode bits kept", v, 32'h3);
    // R10 capture of a wide count
    wr(5'h0C, 32'h2); wr(5'h08, 32'h0);
    wr(5'h04, 32'h4);
    wr(5'h14, 32'h0);
    rd(5'h14, v); chk("R10 capture high", v, 32'h2);
    rd(5'h10, v); chk("R10 capture low", v, 32'h0);
    wr(5'h04, 32'h8);
    // R9 timeout beats clear, L=0 continuous
    wr(5'h0C, 32'h0);
    wr(5'h04, 32'h6);
    repeat (2) @(negedge clk);
    wr(5'h00, 32'h0);
    rd(5'h00, v); chk("R9 timeout wins over clear", v, 32'h3);
    wr(5'h04, 32'h8);
    // R1 unmapped and misaligned
    wr(5'h18, 32'hFFFF_FFFF);
    rd(5'h18, v); chk("R1 unmapped word", v, 32'h0);
    wr(5'h09, 32'h0000_1234);
    rd(5'h09, v); chk("R1 misaligned read", v, 32'h0);
    rd(5'h08, v); chk("R1 misaligned write ignored", v, 32'h0);
    repeat (2) @(negedge clk);
    finish_run();
  end
endmodule